// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block controls 32 general-purpose pins through a small register port. Software writes an output value and an output-enable per pin. It reads back the pad levels after they pass a two-flop synchronizer. Each pin can also raise an interrupt.

Per pin, a 2-bit condition code selects low level, high level, rising edge or falling edge. An extra per-pin bit can override the code so that either edge triggers. A triggered condition sets a sticky status bit. Software clears a status bit by writing a one to it. An interrupt mask gates the status bits onto two request lines, one for the lower half of the pins and one for the upper half.

Registers sit at word-aligned byte offsets on a 5-bit address. Reads return data one cycle after the request. The reset input is expected to be asserted asynchronously and released in step with the clock.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, pad_out, pad_oe, rdata, irq_lo and irq_hi are 0, and the data, direction, configuration, mask, status and edge-select registers read 0 (status may then be set by conditions, see R4).
- R2: A write to offset 0x00 sets pad_out to the written value and a read of 0x00 returns it. A write to offset 0x04 sets pad_oe, where bit value 1 means the pin drives and 0 means input.
- R3: A read of offset 0x08 returns the pad inputs after a two-flop synchronizer. A level applied before clock edge A is first returned by a read issued at edge A+2. Writes to 0x08 have no effect.
- R4: The condition codes are: 0 = level low, 1 = level high, 2 = rising edge, 3 = falling edge. An edge is a difference between the synchronized value and its value one cycle earlier. A met condition sets the pin's status bit.
- R5: Pins 0–15 take their code from offset 0x0C, bits [2p+1:2p]. Pins 16–31 take their code from offset 0x10, bits [2(p−16)+1:2(p−16)].
- R6: When bit p of the edge-select register (offset 0x1C) is 1, any change on pin p sets its status bit, and the pin's condition code is ignored.
- R7: The status register (offset 0x18) is sticky. Writing 1 to a bit clears it. Writing 0 leaves the bit unchanged.
- R8: A level condition sets its status bit on every cycle it holds. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R9: irq_lo is high exactly when some pin in 0–15 has both status and mask bit set (mask at offset 0x14). irq_hi covers pins 16–31 in the same way.
- R10: rdata updates one cycle after rd_en and holds its value while rd_en is low. An access whose addr[1:0] is not 0 is ignored on write and returns 0 on read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata valid the next cycle |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_lo | output | 1 | Masked interrupt request, pins 0–15 |
| irq_hi | output | 1 | Masked interrupt request, pins 16–31 |

## Verification
The bench measures the synchronizer latency exactly, with two reads that must still return the old pad value and then one that returns the new one. A design with one flop too many or too few fails this test.

It drives a set and a clear onto one held level-high pin in the same cycle. A design that lets the clear win would lose an interrupt that is still active.

Each edge type is tested against the opposite code, and the edge-select override is tested with a falling edge on a pin coded for rising. A design that swapped the codes, or ignored the override, would set the wrong status bits.

Unaligned accesses, writes to the read-only pad register, and lower-half versus upper-half interrupt routing are also tested. A wrong half split would raise the wrong request line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } cond_e;

  // word index = addr[4:2]
  localparam logic [2:0] IDX_DATA   = 3'd0;
  localparam logic [2:0] IDX_DIR    = 3'd1;
  localparam logic [2:0] IDX_PAD    = 3'd2;
  localparam logic [2:0] IDX_CFG_LO = 3'd3;
  localparam logic [2:0] IDX_CFG_HI = 3'd4;
  localparam logic [2:0] IDX_MASK   = 3'd5;
  localparam logic [2:0] IDX_STAT   = 3'd6;
  localparam logic [2:0] IDX_EDGE   = 3'd7;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0]   cur_i,
  input  logic [NPINS-1:0]   prev_i,
  input  logic [2*NPINS-1:0] cond_i,
  input  logic [NPINS-1:0]   any_edge_i,
  output logic [NPINS-1:0]   evt_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    cond_e code;
    logic  hit;
    assign code = cond_e'(cond_i[2*p +: 2]);

    always_comb begin
      unique case (code)
        COND_LOW:  hit = !cur_i[p];
        COND_HIGH: hit = cur_i[p];
        COND_RISE: hit = cur_i[p] && !prev_i[p];
        default:   hit = !cur_i[p] && prev_i[p];
      endcase
    end

    assign evt_o[p] = any_edge_i[p] ? (cur_i[p] ^ prev_i[p]) : hit;
  end

endmodule

// File: rtl/gpio_stat_w1c.sv
module gpio_stat_w1c #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] stat_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);

  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] stat_q;
  logic [NPINS-1:0] stat_d;
  logic [NPINS-1:0] pend;

  always_comb begin
    stat_d = (stat_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign pend     = stat_q & mask_i;
  assign irq_lo_o = |pend[HALF-1:0];
  assign irq_hi_o = |pend[NPINS-1:HALF];
  assign stat_o   = stat_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam int unsigned HALF  = NPINS / 2;
  localparam int unsigned CFG_W = 2 * HALF;

  logic [NPINS-1:0]  data_q, dir_q, mask_q, edge_q;
  logic [CFG_W-1:0]  cfg_lo_q, cfg_hi_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic [NPINS-1:0]  sync_val, sync_prev, evt, stat_q, w1c;
  logic [2:0]        idx;
  logic              aligned;
  logic              en_data, en_dir, en_cfg_lo, en_cfg_hi, en_mask, en_edge;

  assign idx     = addr[4:2];
  assign aligned = (addr[1:0] == 2'b00);

  // clock enables
  always_comb begin
    en_data   = wr_en && aligned && (idx == IDX_DATA);
    en_dir    = wr_en && aligned && (idx == IDX_DIR);
    en_cfg_lo = wr_en && aligned && (idx == IDX_CFG_LO);
    en_cfg_hi = wr_en && aligned && (idx == IDX_CFG_HI);
    en_mask   = wr_en && aligned && (idx == IDX_MASK);
    en_edge   = wr_en && aligned && (idx == IDX_EDGE);
    w1c       = (wr_en && aligned && (idx == IDX_STAT)) ? wdata[NPINS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      edge_q   <= '0;
    end else begin
      if (en_data)   data_q   <= wdata[NPINS-1:0];
      if (en_dir)    dir_q    <= wdata[NPINS-1:0];
      if (en_cfg_lo) cfg_lo_q <= wdata[CFG_W-1:0];
      if (en_cfg_hi) cfg_hi_q <= wdata[CFG_W-1:0];
      if (en_mask)   mask_q   <= wdata[NPINS-1:0];
      if (en_edge)   edge_q   <= wdata[NPINS-1:0];
    end
  end

  gpio_in_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_in),
    .sync_o  (sync_val),
    .prev_o  (sync_prev)
  );

  gpio_evt_detect #(
    .NPINS (NPINS)
  ) u_detect (
    .cur_i      (sync_val),
    .prev_i     (sync_prev),
    .cond_i     ({cfg_hi_q, cfg_lo_q}),
    .any_edge_i (edge_q),
    .evt_o      (evt)
  );

  gpio_stat_w1c #(
    .NPINS (NPINS)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (w1c),
    .set_i    (evt),
    .mask_i   (mask_q),
    .stat_o   (stat_q),
    .irq_lo_o (irq_lo),
    .irq_hi_o (irq_hi)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (idx)
        IDX_DATA:   rd_mux = DATA_W'(data_q);
        IDX_DIR:    rd_mux = DATA_W'(dir_q);
        IDX_PAD:    rd_mux = DATA_W'(sync_val);
        IDX_CFG_LO: rd_mux = DATA_W'(cfg_lo_q);
        IDX_CFG_HI: rd_mux = DATA_W'(cfg_hi_q);
        IDX_MASK:   rd_mux = DATA_W'(mask_q);
        IDX_STAT:   rd_mux = DATA_W'(stat_q);
        default:    rd_mux = DATA_W'(edge_q);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [NPINS-1:0]  stat,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  sync_val
);

  localparam int unsigned HALF = NPINS / 2;

  logic             wr_data, wr_dir, rd_pad;
  logic [NPINS-1:0] clr_req;

  assign wr_data = wr_en && (addr == {IDX_DATA, 2'b00});
  assign wr_dir  = wr_en && (addr == {IDX_DIR, 2'b00});
  assign rd_pad  = rd_en && (addr == {IDX_PAD, 2'b00});
  assign clr_req = (wr_en && (addr == {IDX_STAT, 2'b00})) ? wdata[NPINS-1:0] : '0;

  // R2: written data and direction reach the pins
  p_data_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (pad_out == $past(wdata[NPINS-1:0])));
  p_dir_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == $past(wdata[NPINS-1:0])));

  // R3: pad read returns synchronized value
  p_pad_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pad |=> (rdata == DATA_W'($past(sync_val))));

  // R4: a status bit only rises because of a detected condition
  p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));

  // R7: a status bit only falls when one was written to it
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~stat & ~$past(clr_req)) == '0));

  // R8: a detected condition always leaves the bit set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat & $past(evt)) == '0));

  // R9: no request line without an unmasked bit in its half
  p_lo_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[HALF-1:0] == '0) |-> !irq_lo);
  p_hi_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[NPINS-1:HALF] == '0) |-> !irq_hi);

  // R10: read data holds without a read
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NPINS  (NPINS),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wdata    (wdata),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .stat     (stat_q),
  .evt      (evt),
  .mask     (mask_q),
  .sync_val (sync_val)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq_lo;
  logic        irq_hi;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [31:0] P = 32'h1234_5678;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi)
  );

  // ---------------- reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_s3, m_data, m_dir, m_clo, m_chi, m_mask, m_stat, m_edge, m_rd;

  function automatic logic [31:0] evt_f(input logic [31:0] cur, input logic [31:0] prv,
                                        input logic [63:0] cfg, input logic [31:0] anye);
    logic [31:0] e;
    for (int i = 0; i < 32; i++) begin
      if (anye[i]) e[i] = cur[i] ^ prv[i];
      else begin
        case (cfg[2*i +: 2])
          2'd0:    e[i] = !cur[i];
          2'd1:    e[i] = cur[i];
          2'd2:    e[i] = cur[i] && !prv[i];
          default: e[i] = !cur[i] && prv[i];
        endcase
      end
    end
    return e;
  endfunction

  function automatic logic [31:0] read_f(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_data;
      3'd1: return m_dir;
      3'd2: return m_s2;
      3'd3: return m_clo;
      3'd4: return m_chi;
      3'd5: return m_mask;
      3'd6: return m_stat;
      default: return m_edge;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_data <= '0; m_dir <= '0;
      m_clo <= '0; m_chi <= '0; m_mask <= '0; m_stat <= '0; m_edge <= '0; m_rd <= '0;
    end else begin
      logic [31:0] clr;
      clr = '0;
      m_s1 <= pad_in; m_s2 <= m_s1; m_s3 <= m_s2;
      if (wr_en && addr[1:0] == 2'b00) begin
        case (addr[4:2])
          3'd0: m_data <= wdata;
          3'd1: m_dir  <= wdata;
          3'd3: m_clo  <= wdata;
          3'd4: m_chi  <= wdata;
          3'd5: m_mask <= wdata;
          3'd6: clr = wdata;
          3'd7: m_edge <= wdata;
          default: ;
        endcase
      end
      m_stat <= (m_stat & ~clr) | evt_f(m_s2, m_s3, {m_chi, m_clo}, m_edge);
      if (rd_en) m_rd <= read_f(addr);
    end
  end

  // ---------------- checking
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R10 rdata vs model", rdata, m_rd);
      check("R2 pad_out vs model", pad_out, m_data);
      check("R2 pad_oe vs model", pad_oe, m_dir);
      check("R9 irq_lo vs model", {31'b0, irq_lo}, {31'b0, |(m_stat[15:0] & m_mask[15:0])});
      check("R9 irq_hi vs model", {31'b0, irq_hi}, {31'b0, |(m_stat[31:16] & m_mask[31:16])});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus
  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0; pad_in = '0;
    #1 rst_n = 1'b0;
    idle(3);
    // R1 reset state
    check("R1 pad_out in reset", pad_out, 32'h0);
    check("R1 pad_oe in reset", pad_oe, 32'h0);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 irq in reset", {30'b0, irq_hi, irq_lo}, 32'h0);
    rst_n = 1'b1;
    rd(5'h14, 32'h0, "R1 mask after reset");
    rd(5'h1C, 32'h0, "R1 edge select after reset");
    rd(5'h0C, 32'h0, "R1 config after reset");
    // R4/R8: low-level code on idle-low pads sets every status bit
    rd(5'h18, 32'hFFFF_FFFF, "R4 low level on all pins");

    // R2 outputs and read-back
    wr(5'h00, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000);
    check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h00, 32'hA5A5_0F0F, "R2 data readback");

    // R3 synchronizer latency
    @(negedge clk);
    pad_in = P; addr = 5'h08; rd_en = 1'b1;
    @(negedge clk); check("R3 pad old (edge A)", rdata, 32'h0);
    @(negedge clk); check("R3 pad old (edge A+1)", rdata, 32'h0);
    @(negedge clk); check("R3 pad new (edge A+2)", rdata, P);
    rd_en = 1'b0;

    // all pins rising, clear status
    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h10, 32'hAAAA_AAAA);
    idle(3);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, 32'h0, "R7 clear all");

    // R4 rising edge pin 0, R9 masking
    @(negedge clk); pad_in = P | 32'h1;
    idle(4);
    rd(5'h18, 32'h1, "R4 rising edge pin 0");
    check("R9 masked off no irq_lo", {31'b0, irq_lo}, 32'h0);
    wr(5'h14, 32'h1);
    check("R9 irq_lo after unmask", {31'b0, irq_lo}, 32'h1);
    check("R9 irq_hi stays low", {31'b0, irq_hi}, 32'h0);

    // R7 write-zero keeps, write-one clears
    wr(5'h18, 32'h0);
    rd(5'h18, 32'h1, "R7 write zero keeps bit");
    wr(5'h18, 32'h1);
    rd(5'h18, 32'h0, "R7 write one clears bit");
    check("R7 irq_lo gone after clear", {31'b0, irq_lo}, 32'h0);
    @(negedge clk); pad_in = P;
    idle(4);
    rd(5'h18, 32'h0, "R4 falling edge ignored on rise code");

    // R5 upper word, pin 17 falling
    wr(5'h10, 32'hAAAA_AAAE);
    @(negedge clk); pad_in = P | (32'h1 << 17);
    idle(4);
    rd(5'h18, 32'h0, "R5 pin 17 rise ignored on fall code");
    @(negedge clk); pad_in = P;
    idle(4);
    rd(5'h18, 32'h1 << 17, "R5 pin 17 falling edge");
    wr(5'h14, 32'h1 << 17);
    check("R9 irq_hi for pin 17", {31'b0, irq_hi}, 32'h1);
    check("R9 irq_lo low for pin 17", {31'b0, irq_lo}, 32'h0);
    wr(5'h18, 32'h1 << 17);
    rd(5'h18, 32'h0, "R7 pin 17 cleared");

    // R6 edge-select override on pin 16 (coded rising)
    wr(5'h1C, 32'h1 << 16);
    @(negedge clk); pad_in = P | (32'h1 << 16);
    idle(4);
    rd(5'h18, 32'h1 << 16, "R6 any-edge rise");
    wr(5'h18, 32'h1 << 16);
    @(negedge clk); pad_in = P;
    idle(4);
    rd(5'h18, 32'h1 << 16, "R6 any-edge fall on rise-coded pin");
    wr(5'h18, 32'h1 << 16);
    rd(5'h18, 32'h0, "R6 cleared");

    // R8 level high on pin 2 wins against clear
    wr(5'h0C, 32'hAAAA_AA9A);
    @(negedge clk); pad_in = P | 32'h4;
    idle(4);
    rd(5'h18, 32'h4, "R4 high level pin 2");
    wr(5'h18, 32'h4);
    rd(5'h18, 32'h4, "R8 set wins over clear");
    @(negedge clk); pad_in = P;
    idle(4);
    wr(5'h18, 32'h4);
    rd(5'h18, 32'h0, "R8 clears once level gone");

    // R10 unaligned and hold, R3 read-only
    wr(5'h01, 32'hFFFF_FFFF);
    check("R10 unaligned write ignored", pad_out, 32'hA5A5_0F0F);
    rd(5'h02, 32'h0, "R10 unaligned read zero");
    rd(5'h00, 32'hA5A5_0F0F, "R10 aligned read");
    idle(5);
    check("R10 rdata holds", rdata, 32'hA5A5_0F0F);
    wr(5'h08, 32'h0);
    rd(5'h08, P, "R3 pad write ignored");

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) pad_in = pad_in ^ (32'h1 << ($urandom % 32));
      wr_en = ($urandom % 4 == 0);
      rd_en = ($urandom % 2 == 0);
      addr  = ($urandom % 5 == 0) ? 5'($urandom % 32) : {3'($urandom % 8), 2'b00};
      wdata = $urandom;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule